// File: doc/BRIEF.md
# Clock-Hand Frame Reclaim Scanner

This block walks a circular table of physical-frame status words and decides, frame by frame, which frames a memory manager may take back. Two hand pointers bound each pass: frames from the start hand up to, but not including, the end hand are examined in ascending order, wrapping past the last frame. Each frame is classified from four status bits. A frame that is in use and recently touched has its referenced bit cleared. A clean, untouched frame is offered for reclaim. A dirty, untouched frame is flagged for write-back. Free frames are passed over.

After the pass, the start hand jumps to the old end hand. The end hand then steps forward by a programmable count and clears the referenced bit of every frame it crosses, which sets up the window for the next pass. A per-frame age counter delays reclaim: a frame is offered only after a programmable number of consecutive clean, untouched examinations. A threshold of one gives immediate reclaim.

The status table lives outside the block and is reached through a synchronous read/write port. Read data returns one cycle after the read strobe. Results leave the block as a stream of single-cycle events, each carrying a frame index and an action code.

Top module: `clk_scan`

## Requirements
- R1: A status word holds valid in bit 0, in-use (reference count nonzero) in bit 1, referenced in bit 2 and modified in bit 3. A frame with bit 0 or bit 1 clear is skipped: no event, no write, and its age counter returns to zero.
- R2: A live frame (bits 0 and 1 set) with bit 2 set is written back with only bit 2 cleared, at the same index. It raises no event, and its age counter returns to zero.
- R3: For a live frame with bits 2 and 3 clear, the age counter is incremented. When the incremented value reaches the threshold, a reclaim event with action code 1 is raised and the counter returns to zero. A threshold of 0 behaves as 1.
- R4: A live frame with bit 2 clear and bit 3 set raises a write-back event with action code 2. The frame is not written, and its age counter returns to zero.
- R5: A pass examines frames in ascending index order from the start hand up to one before the end hand, wrapping from the last frame to frame 0. Events leave in that order.
- R6: When the two hands are equal at the start of a pass, every frame is examined exactly once, beginning at the start hand.
- R7: When a pass ends, the start hand takes the old end hand's value. Both hands hold their values while the block is idle.
- R8: After the pass, the end hand advances by the advance count, modulo the table size. Every frame it crosses has bit 2 cleared and no event is raised. An advance count of 0 leaves the end hand unchanged.
- R9: `busy_o` is high from the cycle after an accepted start until completion. `done_o` pulses for one cycle with `busy_o` low. A start while busy is ignored, and the port never reads and writes in the same cycle.
- R10: After reset, both hands are 0, every age counter is 0, and `busy_o`, `done_o` and `ev_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin one pass plus hand advance |
| adv_i | input | AW+1 | Frames the end hand advances after the pass |
| thresh_i | input | AGE_W | Examinations needed before reclaim |
| mem_addr_o | output | AW | Status table index |
| mem_re_o | output | 1 | Read strobe; data valid next cycle |
| mem_we_o | output | 1 | Write strobe |
| mem_wdata_o | output | 4 | Status word to write |
| mem_rdata_i | input | 4 | Status word read |
| ev_valid_o | output | 1 | Event present |
| ev_frame_o | output | AW | Frame index of event |
| ev_act_o | output | 2 | 1 = reclaim, 2 = write back |
| busy_o | output | 1 | Pass or advance in progress |
| done_o | output | 1 | One-cycle completion pulse |
| start_hand_o | output | AW | Current start hand |
| end_hand_o | output | AW | Current end hand |

## Verification
The bench builds the block with its defaults: a 64-frame table and 3-bit age counters. This makes thresholds up to 7 reachable, and the bench uses a threshold of 3 across consecutive full passes to show delayed reclaim and a counter reset by an intervening reference. An advance count of 60 from hand position 10 pushes the end hand across the wrap from frame 63 to frame 0. Equal hands produce whole-table passes starting at nonzero positions.

// File: rtl/clk_scan_pkg.sv
package clk_scan_pkg;

    localparam int unsigned ST_W     = 4;
    localparam int unsigned ST_VALID = 0;
    localparam int unsigned ST_INUSE = 1;
    localparam int unsigned ST_REF   = 2;
    localparam int unsigned ST_MOD   = 3;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_STEAL = 2'd1,
        ACT_CLEAN = 2'd2
    } act_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_SW_RD = 3'd1,
        S_SW_EV = 3'd2,
        S_SW_WB = 3'd3,
        S_AD_RD = 3'd4,
        S_AD_EV = 3'd5,
        S_AD_WB = 3'd6
    } state_e;

endpackage

// File: rtl/clk_scan_classify.sv
module clk_scan_classify
    import clk_scan_pkg::*;
#(
    parameter int unsigned AGE_W = 3
) (
    input  logic [ST_W-1:0]  status_i,
    input  logic [AGE_W-1:0] age_i,
    input  logic [AGE_W-1:0] thr_i,
    output act_e             act_o,
    output logic [AGE_W-1:0] age_o,
    output logic             wb_o,
    output logic [ST_W-1:0]  wb_data_o
);

    logic [AGE_W:0] age_inc;
    logic [AGE_W:0] thr_eff;
    logic           live;

    always_comb begin
        age_inc   = {1'b0, age_i} + (AGE_W+1)'(1);
        thr_eff   = (thr_i == '0) ? (AGE_W+1)'(1) : {1'b0, thr_i};
        live      = status_i[ST_VALID] & status_i[ST_INUSE];
        act_o     = ACT_NONE;
        age_o     = '0;
        wb_o      = 1'b0;
        wb_data_o = status_i;
        wb_data_o[ST_REF] = 1'b0;
        if (live) begin
            if (status_i[ST_REF]) begin
                wb_o = 1'b1;
            end else if (status_i[ST_MOD]) begin
                act_o = ACT_CLEAN;
            end else if (age_inc >= thr_eff) begin
                act_o = ACT_STEAL;
            end else begin
                age_o = age_inc[AGE_W-1:0];
            end
        end
    end

endmodule

// File: rtl/clk_scan_agebank.sv
module clk_scan_agebank #(
    parameter int unsigned N_FRAMES = 64,
    parameter int unsigned AGE_W    = 3,
    localparam int unsigned AW      = $clog2(N_FRAMES)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [AW-1:0]    rd_idx_i,
    output logic [AGE_W-1:0] rd_age_o,
    input  logic             we_i,
    input  logic [AW-1:0]    wr_idx_i,
    input  logic [AGE_W-1:0] wr_age_i
);

    logic [AGE_W-1:0] ages [N_FRAMES];

    for (genvar g = 0; g < N_FRAMES; g++) begin : g_cell
        logic [AGE_W-1:0] cell_d;
        logic [AGE_W-1:0] cell_q;

        always_comb begin
            cell_d = cell_q;
            if (we_i && (wr_idx_i == AW'(g))) begin
                cell_d = wr_age_i;
            end
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) cell_q <= '0;
            else         cell_q <= cell_d;
        end

        assign ages[g] = cell_q;
    end

    assign rd_age_o = ({1'b0, rd_idx_i} < (AW+1)'(N_FRAMES)) ? ages[rd_idx_i] : '0;

endmodule

// File: rtl/clk_scan.sv
module clk_scan
    import clk_scan_pkg::*;
#(
    parameter int unsigned N_FRAMES = 64,
    parameter int unsigned AGE_W    = 3,
    localparam int unsigned AW      = $clog2(N_FRAMES),
    localparam int unsigned LW      = AW + 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [LW-1:0]    adv_i,
    input  logic [AGE_W-1:0] thresh_i,
    output logic [AW-1:0]    mem_addr_o,
    output logic             mem_re_o,
    output logic             mem_we_o,
    output logic [ST_W-1:0]  mem_wdata_o,
    input  logic [ST_W-1:0]  mem_rdata_i,
    output logic             ev_valid_o,
    output logic [AW-1:0]    ev_frame_o,
    output logic [1:0]       ev_act_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [AW-1:0]    start_hand_o,
    output logic [AW-1:0]    end_hand_o
);

    typedef struct packed {
        state_e           state;
        logic [AW-1:0]    shand;
        logic [AW-1:0]    ehand;
        logic [AW-1:0]    cur;
        logic [LW-1:0]    left;
        logic [LW-1:0]    adv;
        logic [AGE_W-1:0] thr;
        logic [ST_W-1:0]  wb;
        logic             ev_v;
        logic [AW-1:0]    ev_f;
        act_e             ev_a;
        logic             done;
    } regs_t;

    regs_t q, d;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] i);
        return (i == AW'(N_FRAMES - 1)) ? '0 : i + AW'(1);
    endfunction

    logic [AGE_W-1:0] cur_age;
    logic [AGE_W-1:0] cls_age;
    act_e             cls_act;
    logic             cls_wb;
    logic [ST_W-1:0]  cls_wdata;
    logic             age_we;
    logic [LW-1:0]    sweep_len;
    logic             sweep_step;
    logic             adv_step;

    clk_scan_agebank #(.N_FRAMES(N_FRAMES), .AGE_W(AGE_W)) u_age (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .rd_idx_i (q.cur),
        .rd_age_o (cur_age),
        .we_i     (age_we),
        .wr_idx_i (q.cur),
        .wr_age_i (cls_age)
    );

    clk_scan_classify #(.AGE_W(AGE_W)) u_cls (
        .status_i  (mem_rdata_i),
        .age_i     (cur_age),
        .thr_i     (q.thr),
        .act_o     (cls_act),
        .age_o     (cls_age),
        .wb_o      (cls_wb),
        .wb_data_o (cls_wdata)
    );

    assign age_we = (q.state == S_SW_EV);

    always_comb begin
        if (q.ehand == q.shand) begin
            sweep_len = LW'(N_FRAMES);
        end else if (q.ehand > q.shand) begin
            sweep_len = {1'b0, q.ehand} - {1'b0, q.shand};
        end else begin
            sweep_len = LW'(N_FRAMES) - {1'b0, q.shand} + {1'b0, q.ehand};
        end
    end

    always_comb begin
        d          = q;
        d.ev_v     = 1'b0;
        d.done     = 1'b0;
        sweep_step = 1'b0;
        adv_step   = 1'b0;
        case (q.state)
            S_IDLE: begin
                if (start_i) begin
                    d.thr   = thresh_i;
                    d.adv   = adv_i;
                    d.cur   = q.shand;
                    d.left  = sweep_len;
                    d.state = S_SW_RD;
                end
            end
            S_SW_RD: d.state = S_SW_EV;
            S_SW_EV: begin
                d.wb = cls_wdata;
                if (cls_act != ACT_NONE) begin
                    d.ev_v = 1'b1;
                    d.ev_f = q.cur;
                    d.ev_a = cls_act;
                end
                if (cls_wb) d.state = S_SW_WB;
                else        sweep_step = 1'b1;
            end
            S_SW_WB: sweep_step = 1'b1;
            S_AD_RD: d.state = S_AD_EV;
            S_AD_EV: begin
                d.wb = cls_wdata;
                if (mem_rdata_i[ST_REF]) d.state = S_AD_WB;
                else                     adv_step = 1'b1;
            end
            S_AD_WB: adv_step = 1'b1;
            default: d.state = S_IDLE;
        endcase

        if (sweep_step) begin
            if (q.left == LW'(1)) begin
                d.shand = q.ehand;
                if (q.adv == '0) begin
                    d.state = S_IDLE;
                    d.done  = 1'b1;
                end else begin
                    d.cur   = q.ehand;
                    d.left  = q.adv;
                    d.state = S_AD_RD;
                end
            end else begin
                d.left  = q.left - LW'(1);
                d.cur   = nxt(q.cur);
                d.state = S_SW_RD;
            end
        end

        if (adv_step) begin
            d.ehand = nxt(q.ehand);
            d.cur   = nxt(q.cur);
            if (q.left == LW'(1)) begin
                d.state = S_IDLE;
                d.done  = 1'b1;
            end else begin
                d.left  = q.left - LW'(1);
                d.state = S_AD_RD;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign mem_addr_o   = q.cur;
    assign mem_re_o     = (q.state == S_SW_RD) || (q.state == S_AD_RD);
    assign mem_we_o     = (q.state == S_SW_WB) || (q.state == S_AD_WB);
    assign mem_wdata_o  = q.wb;
    assign ev_valid_o   = q.ev_v;
    assign ev_frame_o   = q.ev_f;
    assign ev_act_o     = q.ev_a;
    assign busy_o       = (q.state != S_IDLE);
    assign done_o       = q.done;
    assign start_hand_o = q.shand;
    assign end_hand_o   = q.ehand;

    // R2
    wb_ref_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_we_o |-> !mem_wdata_o[ST_REF]);

    // R2
    wb_keep_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_we_o |-> (mem_wdata_o[ST_MOD] == $past(mem_rdata_i[ST_MOD])) &&
                     (mem_wdata_o[ST_INUSE:ST_VALID] == $past(mem_rdata_i[ST_INUSE:ST_VALID])) &&
                     (mem_addr_o == $past(mem_addr_o)));

    // R3
    steal_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ev_valid_o && ev_act_o == ACT_STEAL) |-> ($past(mem_rdata_i) == 4'b0011));

    // R4
    clean_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ev_valid_o && ev_act_o == ACT_CLEAN) |-> ($past(mem_rdata_i) == 4'b1011));

    // R9
    done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o);

    // R9
    port_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(mem_re_o && mem_we_o));

    // R7
    hands_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |=> ($stable(start_hand_o) && $stable(end_hand_o)));

endmodule

// File: tb/sim_clk_scan.sv
`timescale 1ns/1ps
module sim_clk_scan;

    localparam int N = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [6:0] adv_r = '0;
    logic [2:0] thr_r = '0;
    logic [5:0] mem_addr;
    logic       mem_re, mem_we;
    logic [3:0] mem_wdata;
    logic [3:0] mem_rdata = '0;
    logic       ev_valid;
    logic [5:0] ev_frame;
    logic [1:0] ev_act;
    logic       busy, done;
    logic [5:0] shand, ehand;

    logic       ld_en = 1'b0;
    logic [5:0] ld_a = '0;
    logic [3:0] ld_d = '0;
    logic [3:0] fm [N];

    int checks = 0;
    int errors = 0;
    int rm [N];
    int rage [N];
    int ms = 0;
    int me = 0;
    int qf [$];
    int qa [$];

    always #4 clk = ~clk;

    clk_scan #(.N_FRAMES(64), .AGE_W(3)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .adv_i(adv_r), .thresh_i(thr_r),
        .mem_addr_o(mem_addr), .mem_re_o(mem_re), .mem_we_o(mem_we),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
        .ev_valid_o(ev_valid), .ev_frame_o(ev_frame), .ev_act_o(ev_act),
        .busy_o(busy), .done_o(done), .start_hand_o(shand), .end_hand_o(ehand)
    );

    always @(posedge clk) begin
        if (ld_en)       fm[ld_a] <= ld_d;
        else if (mem_we) fm[mem_addr] <= mem_wdata;
        if (mem_re)      mem_rdata <= fm[mem_addr];
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic poke(input int idx, input int val);
        @(negedge clk);
        ld_en = 1'b1; ld_a = 6'(idx); ld_d = 4'(val);
        rm[idx] = val;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic load(input int kind);
        for (int i = 0; i < N; i++) begin
            int v;
            if (kind == 0) v = (i * 11 + 7) % 16;
            else if (i % 4 == 0) v = 3;
            else if (i % 4 == 1) v = 7;
            else v = 1;
            poke(i, v);
        end
    endtask

    task automatic model(input int adv, input int thr);
        int n, idx, w, t;
        n = (me == ms) ? N : ((me - ms + N) % N);
        idx = ms;
        t = (thr == 0) ? 1 : thr;
        for (int k = 0; k < n; k++) begin
            w = rm[idx];
            if ((w & 1) == 0 || (w & 2) == 0) begin
                rage[idx] = 0;
            end else if ((w & 4) != 0) begin
                rm[idx] = w & 11;
                rage[idx] = 0;
            end else if ((w & 8) != 0) begin
                qf.push_back(idx); qa.push_back(2);
                rage[idx] = 0;
            end else begin
                rage[idx]++;
                if (rage[idx] >= t) begin
                    qf.push_back(idx); qa.push_back(1);
                    rage[idx] = 0;
                end
            end
            idx = (idx + 1) % N;
        end
        ms = me;
        for (int k = 0; k < adv; k++) begin
            rm[me] = rm[me] & 11;
            me = (me + 1) % N;
        end
    endtask

    task automatic run(input int adv, input int thr, input bit glitch);
        int cyc;
        bit fin;
        int bad;
        model(adv, thr);
        @(negedge clk);
        start = 1'b1; adv_r = 7'(adv); thr_r = 3'(thr);
        @(negedge clk);
        start = 1'b0;
        cyc = 0; fin = 1'b0;
        while (!fin && cyc < 3000) begin
            if (ev_valid) begin
                if (qf.size() == 0) begin
                    chk(1'b0, "R5", "unexpected event frame", int'(ev_frame), -1);
                end else begin
                    int ef, ea;
                    ef = qf.pop_front(); ea = qa.pop_front();
                    chk(int'(ev_frame) == ef, "R5", "event frame order", int'(ev_frame), ef);
                    if (ea == 1) chk(int'(ev_act) == ea, "R3", "reclaim action", int'(ev_act), ea);
                    else         chk(int'(ev_act) == ea, "R4", "write-back action", int'(ev_act), ea);
                end
            end
            if (done) begin
                fin = 1'b1;
                chk(!busy, "R9", "busy low at done", int'(busy), 0);
            end
            start = (glitch && cyc == 6) ? 1'b1 : 1'b0;
            if (!fin) begin
                @(negedge clk);
                cyc++;
            end
        end
        start = 1'b0;
        chk(fin, "R9", "done pulse seen (watchdog)", int'(fin), 1);
        chk(qf.size() == 0, "R6", "missing events", qf.size(), 0);
        qf.delete(); qa.delete();
        chk(int'(shand) == ms, "R7", "start hand", int'(shand), ms);
        chk(int'(ehand) == me, "R8", "end hand", int'(ehand), me);
        bad = -1;
        for (int i = 0; i < N; i++) if (bad < 0 && int'(fm[i]) != rm[i]) bad = i;
        if (bad < 0) chk(1'b1, "R2", "table contents", 0, 0);
        else         chk(1'b0, "R2", "table contents (R1 R8) at frame", int'(fm[bad]), rm[bad]);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin rm[i] = 0; rage[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(!busy, "R10", "busy after reset", int'(busy), 0);
        chk(!done, "R10", "done after reset", int'(done), 0);
        chk(!ev_valid, "R10", "event after reset", int'(ev_valid), 0);
        chk(shand == 0 && ehand == 0, "R10", "hands after reset", int'(shand) + int'(ehand), 0);

        load(0);
        run(10, 1, 1'b0);          // R6 full pass from 0, R1..R4 mix, R8 advance 10
        run(0, 0, 1'b0);           // R5 partial pass 0..9, threshold 0 as 1, advance 0
        run(60, 1, 1'b0);          // R6 full pass from 10 with wrap, R8 end hand wraps to 6

        load(1);
        run(0, 3, 1'b0);           // R3 aging across passes
        run(0, 3, 1'b1);           // R9 start while busy ignored
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            chk(!busy && !ev_valid, "R9", "idle after ignored start", int'(busy), 0);
        end
        poke(8, 7);                // R2 reference resets the age of frame 8
        run(0, 3, 1'b0);
        run(0, 3, 1'b0);
        run(0, 3, 1'b0);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule